// File: doc/BRIEF.md
# Phase-Accumulator Waveform Generator

This block is a single-channel numerically controlled oscillator. On every clock a 32-bit phase register advances by a programmable step and wraps freely past its top. The upper eight bits of that register, rotated by a per-channel phase offset, select a point on the waveform. The waveform is either a sine taken from a 256-entry table or a square wave.

The chosen shape is mapped onto an output span given by two codes: a low level and a high level. Swapping the two codes inverts the waveform instead of clamping it. A sync line follows the undelayed phase and is high during the first half of every period. Two channels that share a step but differ in offset by a quarter turn produce sine and cosine.

The block suits a bank of signal-generator channels that feed DACs. It produces one 12-bit code per clock, with a valid flag that rises once the pipeline holds real data.

Top module: `wavegen_nco`

## Requirements
- R1: On every running clock the phase register (reset value 0) adds `freq_word`, modulo 2^32, with no saturation.
- R2: The table address is bits [31:24] of the phase register plus `phase_ofs`, modulo 256.
- R3: In sine mode the shape value at address k is floor(2048 + 2047*sin(2*pi*k/256) + 0.5).
- R4: In square mode the shape value is 4096 while bit 7 of the address is 0, and 0 otherwise. The output is therefore exactly `lvl_max` or `lvl_min`.
- R5: `sample` = `lvl_min` + floor((`lvl_max` - `lvl_min`) * shape / 4096), using signed arithmetic. When `lvl_min` > `lvl_max` the waveform comes out inverted, and the result stays between the two codes.
- R6: The sample, sync and validity seen after clock edge n+3 come from the phase register value and the configuration inputs present at edge n. `sample_vld` rises 3 edges after the first running edge and then stays high.
- R7: While `rst_n` is low, `sample`, `sync_out` and `sample_vld` are 0, with asynchronous effect. After release the block needs two edges and starts running at the third. Until `sample_vld` rises, `sample` and `sync_out` stay 0.
- R8: `sync_out` is 1 exactly when bit 31 of the phase register is 0. `phase_ofs` has no effect on it.
- R9: `wave_sel` = 0 selects the sine and `wave_sel` = 1 selects the square. The selection can change between any two clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| freq_word | input | 32 | Phase step added every clock |
| phase_ofs | input | 8 | Phase rotation added to the table address |
| lvl_min | input | 12 | Code output at the waveform low point |
| lvl_max | input | 12 | Code output at the waveform high point |
| wave_sel | input | 1 | 0 sine, 1 square |
| sample_vld | output | 1 | Pipeline holds real data |
| sample | output | 12 | Output code |
| sync_out | output | 1 | High for the first half of each period |

## Verification
A corrupted phase register would move every later sample and sync edge. Because the register accumulates, the error never fades, so the per-clock model comparison catches it within four cycles. A wrong offset addition or table entry shows up as a code mismatch in the very cycle that address is used. A sign error in the scaler shows up the first time the levels are swapped. A misaligned pipeline stage shows up as a mismatch the moment the configuration changes mid-run, since samples then pair the new settings with the wrong phase.

// File: rtl/wavegen_pkg.sv
package wavegen_pkg;

  typedef enum logic {
    WAVE_SINE   = 1'b0,
    WAVE_SQUARE = 1'b1
  } wave_e;

  // Sine table entry k of depth entries, unsigned, samp_w bits, centred.
  function automatic int sine_code(input int k, input int depth, input int samp_w);
    real ang;
    real mid;
    ang = 2.0 * 3.141592653589793 * real'(k) / real'(depth);
    mid = real'(2 ** (samp_w - 1));
    return $rtoi(mid + (mid - 1.0) * $sin(ang) + 0.5);
  endfunction

endpackage

// File: rtl/wg_rst_sync.sv
module wg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_sync_n = hold_q;
endmodule

// File: rtl/wg_phase_acc.sv
module wg_phase_acc #(
  parameter int PHASE_W = 32,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst_sync_n,
  input  logic               en,
  input  logic [PHASE_W-1:0] freq_word,
  output logic [ADDR_W-1:0]  acc_top
);
  logic [PHASE_W-1:0] acc_q;
  logic [PHASE_W-1:0] acc_d;

  always_comb begin
    acc_d = acc_q;
    if (en) acc_d = acc_q + freq_word;  // wraps modulo 2^PHASE_W
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) acc_q <= '0;
    else             acc_q <= acc_d;
  end

  assign acc_top = acc_q[PHASE_W-1 -: ADDR_W];
endmodule

// File: rtl/wg_shaper.sv
module wg_shaper
  import wavegen_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int SAMP_W = 12
) (
  input  logic              clk,
  input  logic              rst_sync_n,
  input  logic              en,
  input  logic [ADDR_W-1:0] acc_top,
  input  logic [ADDR_W-1:0] phase_ofs,
  input  logic              wave_sel,
  input  logic [SAMP_W-1:0] lvl_min,
  input  logic [SAMP_W-1:0] lvl_max,
  output logic [SAMP_W:0]   shape_o,
  output logic [SAMP_W-1:0] min_o,
  output logic [SAMP_W-1:0] max_o,
  output logic              sync_o
);
  localparam int DEPTH = 2 ** ADDR_W;
  localparam logic [SAMP_W:0] FULL = (SAMP_W+1)'(2 ** SAMP_W);

  logic [SAMP_W-1:0] rom [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_rom
    localparam int CODE = sine_code(k, DEPTH, SAMP_W);
    assign rom[k] = SAMP_W'(CODE);
  end

  // stage 1: address forming, config captured with the phase
  logic [ADDR_W-1:0] ph1_q, ph1_d;
  logic              sel1_q, sel1_d;
  logic [SAMP_W-1:0] min1_q, min1_d, max1_q, max1_d;
  logic              sync1_q, sync1_d;

  always_comb begin
    ph1_d   = ph1_q;
    sel1_d  = sel1_q;
    min1_d  = min1_q;
    max1_d  = max1_q;
    sync1_d = sync1_q;
    if (en) begin
      ph1_d   = acc_top + phase_ofs;
      sel1_d  = wave_sel;
      min1_d  = lvl_min;
      max1_d  = lvl_max;
      sync1_d = ~acc_top[ADDR_W-1];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ph1_q   <= '0;
      sel1_q  <= 1'b0;
      min1_q  <= '0;
      max1_q  <= '0;
      sync1_q <= 1'b0;
    end else begin
      ph1_q   <= ph1_d;
      sel1_q  <= sel1_d;
      min1_q  <= min1_d;
      max1_q  <= max1_d;
      sync1_q <= sync1_d;
    end
  end

  // stage 2: shape selection
  logic [SAMP_W:0]   shp2_q, shp2_d;
  logic [SAMP_W-1:0] min2_q, min2_d, max2_q, max2_d;
  logic              sync2_q, sync2_d;

  always_comb begin
    shp2_d  = shp2_q;
    min2_d  = min2_q;
    max2_d  = max2_q;
    sync2_d = sync2_q;
    if (en) begin
      if (wave_e'(sel1_q) == WAVE_SQUARE)
        shp2_d = ph1_q[ADDR_W-1] ? '0 : FULL;
      else
        shp2_d = {1'b0, rom[ph1_q]};
      min2_d  = min1_q;
      max2_d  = max1_q;
      sync2_d = sync1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      shp2_q  <= '0;
      min2_q  <= '0;
      max2_q  <= '0;
      sync2_q <= 1'b0;
    end else begin
      shp2_q  <= shp2_d;
      min2_q  <= min2_d;
      max2_q  <= max2_d;
      sync2_q <= sync2_d;
    end
  end

  assign shape_o = shp2_q;
  assign min_o   = min2_q;
  assign max_o   = max2_q;
  assign sync_o  = sync2_q;
endmodule

// File: rtl/wg_scaler.sv
module wg_scaler #(
  parameter int SAMP_W = 12
) (
  input  logic              clk,
  input  logic              rst_sync_n,
  input  logic              en,
  input  logic [SAMP_W:0]   shape_i,
  input  logic [SAMP_W-1:0] min_i,
  input  logic [SAMP_W-1:0] max_i,
  input  logic              sync_i,
  output logic [SAMP_W-1:0] sample_o,
  output logic              sync_o
);
  localparam int DW = SAMP_W + 1;
  localparam int SW = SAMP_W + 2;
  localparam int PW = DW + SW;

  logic signed [DW-1:0] diff;
  logic signed [SW-1:0] shp_s;

  assign diff  = $signed({1'b0, max_i}) - $signed({1'b0, min_i});
  assign shp_s = $signed({1'b0, shape_i});

  // stage 3: product
  logic signed [PW-1:0] prod_q, prod_d;
  logic [SAMP_W-1:0]    min3_q, min3_d;
  logic                 sync3_q, sync3_d;

  always_comb begin
    prod_d  = prod_q;
    min3_d  = min3_q;
    sync3_d = sync3_q;
    if (en) begin
      prod_d  = PW'(diff) * PW'(shp_s);
      min3_d  = min_i;
      sync3_d = sync_i;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      prod_q  <= '0;
      min3_q  <= '0;
      sync3_q <= 1'b0;
    end else begin
      prod_q  <= prod_d;
      min3_q  <= min3_d;
      sync3_q <= sync3_d;
    end
  end

  // stage 4: offset add
  logic signed [PW-1:0] sum;
  logic [SAMP_W-1:0]    smp4_q, smp4_d;
  logic                 sync4_q, sync4_d;

  assign sum = $signed({{(PW-SAMP_W){1'b0}}, min3_q}) + (prod_q >>> SAMP_W);

  always_comb begin
    smp4_d  = smp4_q;
    sync4_d = sync4_q;
    if (en) begin
      smp4_d  = SAMP_W'(sum);
      sync4_d = sync3_q;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      smp4_q  <= '0;
      sync4_q <= 1'b0;
    end else begin
      smp4_q  <= smp4_d;
      sync4_q <= sync4_d;
    end
  end

  assign sample_o = smp4_q;
  assign sync_o   = sync4_q;
endmodule

// File: rtl/wavegen_nco.sv
module wavegen_nco #(
  parameter int PHASE_W = 32,
  parameter int ADDR_W  = 8,
  parameter int SAMP_W  = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PHASE_W-1:0] freq_word,
  input  logic [ADDR_W-1:0]  phase_ofs,
  input  logic [SAMP_W-1:0]  lvl_min,
  input  logic [SAMP_W-1:0]  lvl_max,
  input  logic               wave_sel,
  output logic               sample_vld,
  output logic [SAMP_W-1:0]  sample,
  output logic               sync_out
);
  localparam int LAT = 4;

  logic              rst_sync_n;
  logic              run_en;
  logic [ADDR_W-1:0] acc_top;
  logic [SAMP_W:0]   shape;
  logic [SAMP_W-1:0] min_s, max_s;
  logic              sync_s;
  logic [LAT-1:0]    vld_q, vld_d;

  assign run_en = 1'b1;

  wg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  wg_phase_acc #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W)) u_acc (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .en         (run_en),
    .freq_word  (freq_word),
    .acc_top    (acc_top)
  );

  wg_shaper #(.ADDR_W(ADDR_W), .SAMP_W(SAMP_W)) u_shape (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .en         (run_en),
    .acc_top    (acc_top),
    .phase_ofs  (phase_ofs),
    .wave_sel   (wave_sel),
    .lvl_min    (lvl_min),
    .lvl_max    (lvl_max),
    .shape_o    (shape),
    .min_o      (min_s),
    .max_o      (max_s),
    .sync_o     (sync_s)
  );

  wg_scaler #(.SAMP_W(SAMP_W)) u_scale (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .en         (run_en),
    .shape_i    (shape),
    .min_i      (min_s),
    .max_i      (max_s),
    .sync_i     (sync_s),
    .sample_o   (sample),
    .sync_o     (sync_out)
  );

  always_comb begin
    vld_d = vld_q;
    if (run_en) vld_d = {vld_q[LAT-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) vld_q <= '0;
    else             vld_q <= vld_d;
  end

  assign sample_vld = vld_q[LAT-1];
endmodule

// File: rtl/wavegen_nco_chk.sv
module wavegen_nco_chk #(
  parameter int SAMP_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [SAMP_W-1:0] lvl_min,
  input logic [SAMP_W-1:0] lvl_max,
  input logic              wave_sel,
  input logic              sample_vld,
  input logic [SAMP_W-1:0] sample,
  input logic              sync_out
);
  // R6: once valid, stays valid until reset
  p_vld_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld |=> sample_vld);

  // R7: before valid, outputs rest at zero
  p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_vld |-> (sample == '0 && !sync_out));

  // R5: output between the levels in force four edges earlier
  p_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld && $past(lvl_min, 4) <= $past(lvl_max, 4)) |->
      (sample >= $past(lvl_min, 4) && sample <= $past(lvl_max, 4)));

  p_in_range_inv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld && $past(lvl_min, 4) > $past(lvl_max, 4)) |->
      (sample <= $past(lvl_min, 4) && sample >= $past(lvl_max, 4)));

  // R4: square mode gives only the two level codes
  p_square_levels_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld && $past(wave_sel, 4)) |->
      (sample == $past(lvl_min, 4) || sample == $past(lvl_max, 4)));
endmodule

bind wavegen_nco wavegen_nco_chk #(.SAMP_W(SAMP_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lvl_min    (lvl_min),
  .lvl_max    (lvl_max),
  .wave_sel   (wave_sel),
  .sample_vld (sample_vld),
  .sample     (sample),
  .sync_out   (sync_out)
);

// File: tb/wavegen_nco_tb.sv
`timescale 1ns/1ps
module wavegen_nco_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] freq_word;
  logic [7:0]  phase_ofs;
  logic [11:0] lvl_min, lvl_max;
  logic        wave_sel;
  logic        sample_vld;
  logic [11:0] sample;
  logic        sync_out;

  int checks = 0;
  int failures = 0;
  string cur_tag = "R3";
  bit done = 1'b0;

  always #5 clk = ~clk;

  wavegen_nco u_dut (
    .clk(clk), .rst_n(rst_n), .freq_word(freq_word), .phase_ofs(phase_ofs),
    .lvl_min(lvl_min), .lvl_max(lvl_max), .wave_sel(wave_sel),
    .sample_vld(sample_vld), .sample(sample), .sync_out(sync_out)
  );

  typedef struct {
    bit [31:0] acc;
    int        ofs;
    int        mn;
    int        mx;
    bit        sel;
  } rec_t;

  rec_t q[$];
  bit [31:0] acc_m;
  int rcnt;

  function automatic int sine_ref(input int k);
    return $rtoi(2048.0 + 2047.0 * $sin(2.0 * 3.141592653589793 * k / 256.0) + 0.5);
  endfunction

  // R1 model: accumulator plus record of inputs seen at each running edge
  always @(posedge clk) begin
    if (!rst_n) begin
      rcnt = 0;
      acc_m = '0;
      q.delete();
    end else if (rcnt < 2) begin
      rcnt++;
    end else begin
      rec_t r;
      r.acc = acc_m; r.ofs = phase_ofs; r.mn = lvl_min; r.mx = lvl_max; r.sel = wave_sel;
      q.push_back(r);
      if (q.size() > 8) void'(q.pop_front());
      acc_m = acc_m + freq_word;
    end
  end

  task automatic check(input string tag, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp_v, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done && rst_n !== 1'bx) begin
      if (!rst_n || rcnt < 2 || q.size() < 4) begin
        check("R7 vld", sample_vld, 0);
        check("R7 sample", sample, 0);
        check("R7 sync", sync_out, 0);
      end else begin
        rec_t r;
        int addr, shp, s;
        r = q[q.size() - 4];
        addr = (int'(r.acc[31:24]) + r.ofs) % 256;
        if (r.sel) shp = (addr >= 128) ? 0 : 4096;
        else       shp = sine_ref(addr);
        s = r.mn + (((r.mx - r.mn) * shp) >>> 12);
        check("R6 vld", sample_vld, 1);
        check({cur_tag, " sample"}, sample, s);
        check("R8 sync", sync_out, r.acc[31] ? 0 : 1);
      end
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    rst_n = 1'b0; freq_word = 32'h0100_0000; phase_ofs = 8'd0;
    lvl_min = 12'd0; lvl_max = 12'd4095; wave_sel = 1'b0;
    run(5);
    rst_n = 1'b1;
    cur_tag = "R3";            // full-scale sine, one address per clock
    run(300);
    cur_tag = "R2"; phase_ofs = 8'd64;   // quarter-turn rotation
    run(280);
    cur_tag = "R4"; wave_sel = 1'b1; freq_word = 32'h0800_0000; phase_ofs = 8'd16;
    run(120);
    cur_tag = "R5"; wave_sel = 1'b0; lvl_min = 12'd3000; lvl_max = 12'd500;
    freq_word = 32'h0123_4567;
    run(300);
    lvl_min = 12'd1000; lvl_max = 12'd1200;
    run(100);
    cur_tag = "R1"; freq_word = 32'hF000_0001; lvl_min = 12'd0; lvl_max = 12'd4095;
    run(120);
    freq_word = 32'h0000_0000;
    run(20);
    freq_word = 32'hFFFF_FFFF;
    run(60);
    cur_tag = "R9"; freq_word = 32'h0200_0000;
    for (int i = 0; i < 40; i++) begin
      wave_sel = ~wave_sel; phase_ofs = 8'(i * 7);
      run(3);
    end
    cur_tag = "R7"; rst_n = 1'b0;   // mid-run reset
    run(4);
    rst_n = 1'b1; wave_sel = 1'b1;
    run(80);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule